// File: doc/BRIEF.md
# USB Host Controller Register File

This block holds the software-visible register set of a two-port USB 1.1 host controller. It sits behind a 32-byte I/O window that accepts byte, word and dword accesses. The window holds the command, status, interrupt-enable, frame-number, frame-list-base and start-of-frame timing registers, plus one control/status word per root port. Reads are combinational from the addressed offset. Writes take effect on a single-cycle strobe.

Toward the rest of the controller, the block does four things:
- It exposes the run state.
- It pulses when frame processing starts, when a register reset happens, and when a port needs a bus reset.
- It takes the frame engine's per-frame interrupt causes and error flags.
- It takes attach and detach events from the ports.

A level interrupt combines masked and unmaskable status conditions. A hidden two-bit cause register records whether a frame produced a completion interrupt, a short-packet interrupt, or both. Software clears this register together with the interrupt status bit.

Every interface is plain control and status. Writes are fire-and-forget strobes and event inputs are single-cycle pulses, so there is no back-pressure anywhere.

Top module: `usbh_regfile`

## Requirements
- R1: After `rst_n` the block reads as follows: command, status, interrupt enable, frame number and frame-list base are 0, SOF timing (byte offset 0x0C) is 64, and each port word is 0x0080. `irq`, `hc_running`, `run_start`, `hc_rst` and `bus_rst` are all 0.
- R2: A command write (word, offset 0x00) that sets bit 0 while the stored bit 0 is 0 clears halted (status bit 5) and pulses `run_start` in the next cycle. A command write with bit 0 equal to 0 sets halted. `hc_running` follows stored command bit 0.
- R3: A status write (word, offset 0x02) clears every status bit written as 1. Writing 1 to bit 0 also clears the hidden cause register. A write of 1 to any other bit leaves the cause register intact.
- R4: `irq` is high when any of these holds: cause bit 0 with enable bit 2, cause bit 1 with enable bit 3, status bit 1 with enable bit 0, status bit 2 with enable bit 1, status bit 3, or status bit 4.
- R5: On `frm_tick` while running, the 11-bit frame number increments and wraps from 2047 to 0. A nonzero `frm_cause` is ORed into the cause register and sets status bit 0. On `frm_tick` while stopped, halted is set and the frame number holds.
- R6: The frame number (word, offset 0x06) is writable only while halted and keeps 11 bits. The frame-list base (dword, offset 0x08) reads back with its low 12 bits zero.
- R7: A command write with bit 2 (global reset) or bit 1 (host reset) applies the following:
  - Command, status, cause, interrupt enable and frame-list base return to 0, and SOF timing returns to 64.
  - The frame number is unchanged.
  - Each port word returns to 0x0080; a port with a device attached also shows bits 0 and 1 and its low-speed bit 8.
  - `hc_rst` pulses.
  - Global reset also pulses `bus_rst` for every attached port; host reset does not.
- R8: A port write keeps the bits of the old value under mask 0x01FB and takes all other bits from the data. It then clears bits 1 and 3 wherever the data has a 1.
- R9: A port write that takes bit 9 from 0 to 1 while a device is attached pulses that port's `bus_rst` in the next cycle. A write with bit 9 already set, or to a port with no device, gives no pulse.
- R10: The port at word offsets 0x10 to 0x1F is selected by offset bits 3:1. Reads of that range for an index at or above the port count return 0xFF7F. The reads of every other unmapped location are listed below.

  | Access | Unmapped reads return |
  |--------|-----------------------|
  | word   | 0xFF7F                |
  | dword  | 0xFFFFFFFF            |
  | byte   | 0xFF                  |
- R11: Attach sets port bits 0 (connected) and 1 (connect change), and sets bit 8 to the device's low-speed flag. Detach of a connected port clears bit 0 and sets bit 1. If the port was enabled (bit 2), detach clears bit 2 and sets bit 3.
- R12: An attach or detach while command bit 3 (global suspend) is set also sets command bit 4 (force resume) and status bit 2 (resume detect).
- R13: Each bit of `err_in` sets a status bit: bit 0 sets bit 1 (transfer error), bit 1 sets bit 3 (system error), and bit 2 sets bit 4 (process error).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| addr | input | 5 | Byte offset in the window |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data for `acc_size`/`addr`, combinational |
| frm_tick | input | 1 | End-of-frame pulse from the frame engine |
| frm_cause | input | 2 | Interrupt causes from the frame just finished |
| err_in | input | 3 | Error-set pulses: transfer, system, process |
| att_evt | input | NPORTS | Per-port device attach pulse |
| det_evt | input | NPORTS | Per-port device detach pulse |
| att_lowspd | input | NPORTS | Low-speed flag sampled with `att_evt` |
| irq | output | 1 | Level interrupt |
| hc_running | output | 1 | Stored run/stop bit |
| run_start | output | 1 | Pulse: frame processing started |
| hc_rst | output | 1 | Pulse: register reset performed |
| bus_rst | output | NPORTS | Per-port bus reset pulse |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Frame-number wrap at 2047: a counter not held to 11 bits would read back 0x800.
- A frame-number write while not halted: a design without that gate would accept the write.
- A status write that clears only the error bit: a design that cleared the cause register on any status write would drop the interrupt early.
- Port writes that mix preserved, taken and write-1-to-clear bits: the table sequence exposes a wrong mask or a missing change-bit clear.
- A second reset write with bit 9 already set: a level-sensitive reset detector would pulse `bus_rst` again.
- Global versus host reset with one port attached: `bus_rst` pulses only in the global case.
- A detach of an enabled port: the enable-change bit must be set.

// File: rtl/usbh_pkg.sv
package usbh_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  // word offsets
  localparam logic [4:0] OFS_CMD   = 5'h00;
  localparam logic [4:0] OFS_STS   = 5'h02;
  localparam logic [4:0] OFS_IEN   = 5'h04;
  localparam logic [4:0] OFS_FRN   = 5'h06;
  localparam logic [4:0] OFS_FLB   = 5'h08;
  localparam logic [4:0] OFS_SOF   = 5'h0C;

  // command bits
  localparam int CMD_RUN   = 0;
  localparam int CMD_HRST  = 1;
  localparam int CMD_GRST  = 2;
  localparam int CMD_SUSP  = 3;
  localparam int CMD_FRES  = 4;

  // status bits
  localparam int ST_INT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_RES    = 2;
  localparam int ST_SYS    = 3;
  localparam int ST_PROC   = 4;
  localparam int ST_HALT   = 5;
  localparam int ST_W      = 6;

  // port word bits
  localparam int PB_CONN   = 0;
  localparam int PB_CCHG   = 1;
  localparam int PB_EN     = 2;
  localparam int PB_ECHG   = 3;
  localparam int PB_LOWSPD = 8;
  localparam int PB_RESET  = 9;
  localparam logic [15:0] PORT_KEEP  = 16'h01FB;
  localparam logic [15:0] PORT_W1C   = 16'h000A;
  localparam logic [15:0] PORT_RSTV  = 16'h0080;

  localparam logic [15:0] RD_NONE_W  = 16'hFF7F;
  localparam logic [7:0]  SOF_RSTV   = 8'd64;
endpackage

// File: rtl/usbh_port_reg.sv
module usbh_port_reg
  import usbh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        grst,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        att,
  input  logic        det,
  input  logic        lowspd,
  output logic [15:0] ctrl,
  output logic        present,
  output logic        bus_rst
);
  logic [15:0] ctrl_q, ctrl_d;
  logic        pres_q, pres_d;
  logic        lsd_q, lsd_d;
  logic        brst_q, brst_d;

  always_comb begin
    ctrl_d = ctrl_q;
    pres_d = pres_q;
    lsd_d  = lsd_q;
    if (wr) begin
      ctrl_d = (ctrl_q & PORT_KEEP) | (wdata & ~PORT_KEEP);
      ctrl_d = ctrl_d & ~(wdata & PORT_W1C);
    end
    if (det) begin
      if (ctrl_d[PB_CONN]) begin
        ctrl_d[PB_CONN] = 1'b0;
        ctrl_d[PB_CCHG] = 1'b1;
      end
      if (ctrl_d[PB_EN]) begin
        ctrl_d[PB_EN]   = 1'b0;
        ctrl_d[PB_ECHG] = 1'b1;
      end
      pres_d = 1'b0;
    end
    if (att) begin
      if (pres_q && ctrl_d[PB_EN]) begin
        ctrl_d[PB_EN]   = 1'b0;
        ctrl_d[PB_ECHG] = 1'b1;
      end
      ctrl_d[PB_CONN]   = 1'b1;
      ctrl_d[PB_CCHG]   = 1'b1;
      ctrl_d[PB_LOWSPD] = lowspd;
      pres_d = 1'b1;
      lsd_d  = lowspd;
    end
    if (soft_rst) begin
      ctrl_d = PORT_RSTV;
      if (pres_d) begin
        ctrl_d[PB_CONN]   = 1'b1;
        ctrl_d[PB_CCHG]   = 1'b1;
        ctrl_d[PB_LOWSPD] = lsd_d;
      end
    end
    brst_d = pres_q && (grst || (wr && wdata[PB_RESET] && !ctrl_q[PB_RESET]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= PORT_RSTV;
      pres_q <= 1'b0;
      lsd_q  <= 1'b0;
      brst_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pres_q <= pres_d;
      lsd_q  <= lsd_d;
      brst_q <= brst_d;
    end
  end

  assign ctrl    = ctrl_q;
  assign present = pres_q;
  assign bus_rst = brst_q;
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen
  import usbh_pkg::*;
(
  input  logic [ST_W-1:0] status,
  input  logic [1:0]      cause,
  input  logic [3:0]      ien,
  output logic            irq
);
  always_comb begin
    irq = (cause[0] & ien[2]) | (cause[1] & ien[3])
        | (status[ST_ERR] & ien[0]) | (status[ST_RES] & ien[1])
        | status[ST_SYS] | status[ST_PROC];
  end
endmodule

// File: rtl/usbh_rd_mux.sv
module usbh_rd_mux
  import usbh_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int FRW    = 11
) (
  input  logic [1:0]              acc_size,
  input  logic [4:0]              addr,
  input  logic [15:0]             cmd,
  input  logic [ST_W-1:0]         status,
  input  logic [15:0]             ien,
  input  logic [FRW-1:0]          frn,
  input  logic [31:0]             flb,
  input  logic [7:0]              sof,
  input  logic [NPORTS-1:0][15:0] ports,
  output logic [31:0]             rdata
);
  logic [2:0] pidx;
  assign pidx = addr[3:1];

  always_comb begin
    rdata = 32'hFFFF_FFFF;
    case (acc_size)
      SZ_BYTE: rdata = (addr == OFS_SOF) ? {24'd0, sof} : 32'h0000_00FF;
      SZ_WORD: begin
        rdata = {16'd0, RD_NONE_W};
        if (addr[4]) begin
          for (int i = 0; i < NPORTS; i++)
            if (pidx == 3'(i)) rdata = {16'd0, ports[i]};
        end else begin
          case (addr)
            OFS_CMD: rdata = {16'd0, cmd};
            OFS_STS: rdata = {{(32-ST_W){1'b0}}, status};
            OFS_IEN: rdata = {16'd0, ien};
            OFS_FRN: rdata = {{(32-FRW){1'b0}}, frn};
            default: ;
          endcase
        end
      end
      SZ_DWORD: if (addr == OFS_FLB) rdata = flb;
      default: ;
    endcase
  end
endmodule

// File: rtl/usbh_regfile.sv
module usbh_regfile
  import usbh_pkg::*;
#(
  parameter int NPORTS    = 2,
  parameter int FRW       = 11,
  parameter int FLB_ALIGN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        acc_size,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frm_tick,
  input  logic [1:0]        frm_cause,
  input  logic [2:0]        err_in,
  input  logic [NPORTS-1:0] att_evt,
  input  logic [NPORTS-1:0] det_evt,
  input  logic [NPORTS-1:0] att_lowspd,
  output logic              irq,
  output logic              hc_running,
  output logic              run_start,
  output logic              hc_rst,
  output logic [NPORTS-1:0] bus_rst
);
  localparam logic [31:0] FLB_MASK = ~((32'd1 << FLB_ALIGN) - 32'd1);

  logic [15:0]     cmd_q, cmd_d;
  logic [ST_W-1:0] status_q, st_d;
  logic [1:0]      cause_q, cause_d;
  logic [15:0]     ie_q, ie_d;
  logic [FRW-1:0]  fr_q, fr_d;
  logic [31:0]     flb_q, flb_d;
  logic [7:0]      sof_q, sof_d;
  logic            rs_pulse_q, rs_pulse_d;
  logic            hr_pulse_q;

  logic w_word, w_cmd, soft_rst, grst, resume_evt;
  logic [NPORTS-1:0][15:0] port_ctrl;
  logic [NPORTS-1:0]       dev_present;

  assign w_word     = wr_en && (acc_size == SZ_WORD);
  assign w_cmd      = w_word && (addr == OFS_CMD);
  assign soft_rst   = w_cmd && (wdata[CMD_HRST] || wdata[CMD_GRST]);
  assign grst       = w_cmd && wdata[CMD_GRST];
  assign resume_evt = (|(att_evt | det_evt)) && cmd_q[CMD_SUSP];

  always_comb begin
    cmd_d   = cmd_q;
    st_d    = status_q;
    cause_d = cause_q;
    ie_d    = ie_q;
    fr_d    = fr_q;
    flb_d   = flb_q;
    sof_d   = sof_q;
    if (w_cmd) begin
      if (wdata[CMD_RUN] && !cmd_q[CMD_RUN]) st_d[ST_HALT] = 1'b0;
      else if (!wdata[CMD_RUN])              st_d[ST_HALT] = 1'b1;
      cmd_d = wdata[15:0];
    end
    if (w_word && addr == OFS_STS) begin
      st_d = st_d & ~wdata[ST_W-1:0];
      if (wdata[ST_INT]) cause_d = 2'b00;
    end
    if (w_word && addr == OFS_IEN) ie_d = wdata[15:0];
    if (w_word && addr == OFS_FRN && status_q[ST_HALT]) fr_d = wdata[FRW-1:0];
    if (wr_en && acc_size == SZ_DWORD && addr == OFS_FLB) flb_d = wdata & FLB_MASK;
    if (wr_en && acc_size == SZ_BYTE && addr == OFS_SOF) sof_d = wdata[7:0];
    if (frm_tick) begin
      if (cmd_q[CMD_RUN]) begin
        fr_d = fr_q + 1'b1;
        if (frm_cause != 2'b00) begin
          cause_d      = cause_d | frm_cause;
          st_d[ST_INT] = 1'b1;
        end
      end else begin
        st_d[ST_HALT] = 1'b1;
      end
    end
    if (err_in[0]) st_d[ST_ERR]  = 1'b1;
    if (err_in[1]) st_d[ST_SYS]  = 1'b1;
    if (err_in[2]) st_d[ST_PROC] = 1'b1;
    if (resume_evt) begin
      cmd_d[CMD_FRES] = 1'b1;
      st_d[ST_RES]    = 1'b1;
    end
    if (soft_rst) begin
      cmd_d   = '0;
      st_d    = '0;
      cause_d = '0;
      ie_d    = '0;
      flb_d   = '0;
      sof_d   = SOF_RSTV;
    end
    rs_pulse_d = w_cmd && wdata[CMD_RUN] && !cmd_q[CMD_RUN] && !soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      status_q   <= '0;
      cause_q    <= '0;
      ie_q       <= '0;
      fr_q       <= '0;
      flb_q      <= '0;
      sof_q      <= SOF_RSTV;
      rs_pulse_q <= 1'b0;
      hr_pulse_q <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      status_q   <= st_d;
      cause_q    <= cause_d;
      ie_q       <= ie_d;
      fr_q       <= fr_d;
      flb_q      <= flb_d;
      sof_q      <= sof_d;
      rs_pulse_q <= rs_pulse_d;
      hr_pulse_q <= soft_rst;
    end
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    usbh_port_reg u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .grst     (grst),
      .wr       (w_word && addr[4] && (addr[3:1] == 3'(i))),
      .wdata    (wdata[15:0]),
      .att      (att_evt[i]),
      .det      (det_evt[i]),
      .lowspd   (att_lowspd[i]),
      .ctrl     (port_ctrl[i]),
      .present  (dev_present[i]),
      .bus_rst  (bus_rst[i])
    );
  end

  usbh_irq_gen u_irq (
    .status (status_q),
    .cause  (cause_q),
    .ien    (ie_q[3:0]),
    .irq    (irq)
  );

  usbh_rd_mux #(.NPORTS(NPORTS), .FRW(FRW)) u_rd (
    .acc_size (acc_size),
    .addr     (addr),
    .cmd      (cmd_q),
    .status   (status_q),
    .ien      (ie_q),
    .frn      (fr_q),
    .flb      (flb_q),
    .sof      (sof_q),
    .ports    (port_ctrl),
    .rdata    (rdata)
  );

  assign hc_running = cmd_q[CMD_RUN];
  assign run_start  = rs_pulse_q;
  assign hc_rst     = hr_pulse_q;
endmodule

// File: rtl/usbh_regfile_chk.sv
module usbh_regfile_chk
  import usbh_pkg::*;
#(
  parameter int NPORTS    = 2,
  parameter int FRW       = 11,
  parameter int FLB_ALIGN = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        acc_size,
  input logic [4:0]        addr,
  input logic [31:0]       wdata,
  input logic              frm_tick,
  input logic [1:0]        frm_cause,
  input logic              irq,
  input logic              run_start,
  input logic              hc_rst,
  input logic [NPORTS-1:0] bus_rst,
  input logic [15:0]       cmd_q,
  input logic [ST_W-1:0]   status_q,
  input logic [15:0]       ie_q,
  input logic [FRW-1:0]    fr_q,
  input logic [31:0]       flb_q,
  input logic [NPORTS-1:0] dev_present
);
  logic wcmd_rst, wfrn;
  assign wcmd_rst = wr_en && acc_size == SZ_WORD && addr == OFS_CMD
                    && (wdata[CMD_HRST] || wdata[CMD_GRST]);
  assign wfrn     = wr_en && acc_size == SZ_WORD && addr == OFS_FRN;

  assert_start_unhalts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> (!status_q[ST_HALT] && cmd_q[CMD_RUN]));

  assert_fatal_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[ST_SYS] || status_q[ST_PROC]) |-> irq);

  assert_tick_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_tick && cmd_q[CMD_RUN] && frm_cause != 2'b00 && !wcmd_rst) |=> status_q[ST_INT]);

  assert_frnum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_tick && !wfrn) |=> $stable(fr_q));

  assert_flb_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flb_q[FLB_ALIGN-1:0] == '0);

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hc_rst |-> (status_q == '0 && ie_q == '0 && cmd_q == '0));

  assert_busrst_dev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_rst) |-> ((bus_rst & ~$past(dev_present)) == '0));
endmodule

bind usbh_regfile usbh_regfile_chk #(.NPORTS(NPORTS), .FRW(FRW), .FLB_ALIGN(FLB_ALIGN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .acc_size    (acc_size),
  .addr        (addr),
  .wdata       (wdata),
  .frm_tick    (frm_tick),
  .frm_cause   (frm_cause),
  .irq         (irq),
  .run_start   (run_start),
  .hc_rst      (hc_rst),
  .bus_rst     (bus_rst),
  .cmd_q       (cmd_q),
  .status_q    (status_q),
  .ie_q        (ie_q),
  .fr_q        (fr_q),
  .flb_q       (flb_q),
  .dev_present (dev_present)
);

// File: tb/sim_usbh_regfile.sv
`timescale 1ns/1ps
module sim_usbh_regfile;
  localparam int NP = 2;
  localparam int NV = 21;
  // entry: wr(1) size(2) addr(5) data(32) exp(32) req(4)
  localparam logic [0:NV-1][75:0] VEC = {
    {1'b0, 2'd0, 5'h0C, 32'h0, 32'h0000_0040, 4'd1},   // R1 sof reset
    {1'b0, 2'd1, 5'h10, 32'h0, 32'h0000_0080, 4'd1},   // R1 port reset value
    {1'b0, 2'd1, 5'h14, 32'h0, 32'h0000_FF7F, 4'd10},  // R10 absent port
    {1'b0, 2'd2, 5'h00, 32'h0, 32'hFFFF_FFFF, 4'd10},  // R10 dword unmapped
    {1'b0, 2'd0, 5'h00, 32'h0, 32'h0000_00FF, 4'd10},  // R10 byte unmapped
    {1'b1, 2'd2, 5'h08, 32'h1234_5ABC, 32'h0, 4'd6},
    {1'b0, 2'd2, 5'h08, 32'h0, 32'h1234_5000, 4'd6},   // R6 base alignment
    {1'b1, 2'd0, 5'h0C, 32'h55, 32'h0, 4'd10},
    {1'b0, 2'd0, 5'h0C, 32'h0, 32'h0000_0055, 4'd10},  // R10 sof byte
    {1'b1, 2'd1, 5'h06, 32'h0123, 32'h0, 4'd6},
    {1'b0, 2'd1, 5'h06, 32'h0, 32'h0000_0000, 4'd6},   // R6 not halted
    {1'b1, 2'd1, 5'h00, 32'h0000, 32'h0, 4'd2},
    {1'b0, 2'd1, 5'h02, 32'h0, 32'h0000_0020, 4'd2},   // R2 halted set
    {1'b1, 2'd1, 5'h06, 32'hFFFF, 32'h0, 4'd6},
    {1'b0, 2'd1, 5'h06, 32'h0, 32'h0000_07FF, 4'd6},   // R6 11 bits
    {1'b1, 2'd1, 5'h12, 32'hFFFF, 32'h0, 4'd8},
    {1'b0, 2'd1, 5'h12, 32'h0, 32'h0000_FE84, 4'd8},   // R8 mask
    {1'b1, 2'd1, 5'h12, 32'h0000, 32'h0, 4'd8},
    {1'b0, 2'd1, 5'h12, 32'h0, 32'h0000_0080, 4'd8},   // R8 restore
    {1'b0, 2'd1, 5'h1E, 32'h0, 32'h0000_FF7F, 4'd10},  // R10 index 7
    {1'b0, 2'd1, 5'h08, 32'h0, 32'h0000_FF7F, 4'd10}   // R10 word unmapped
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, frm_tick = 1'b0;
  logic [1:0] acc_size = 2'd1, frm_cause = 2'd0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] err_in = '0;
  logic [NP-1:0] att_evt = '0, det_evt = '0, att_lowspd = '0, bus_rst;
  logic irq, hc_running, run_start, hc_rst;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usbh_regfile #(.NPORTS(NP)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; acc_size = sz; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] sz, input logic [4:0] a, input logic [31:0] e);
    @(negedge clk);
    acc_size = sz; addr = a;
    #1 chk(req, rdata, e);
  endtask

  task automatic tick(input logic [1:0] c);
    @(negedge clk);
    frm_tick = 1'b1; frm_cause = c;
    @(negedge clk);
    frm_tick = 1'b0; frm_cause = 2'd0;
  endtask

  task automatic pulse_err(input logic [2:0] e);
    @(negedge clk); err_in = e;
    @(negedge clk); err_in = '0;
  endtask

  task automatic port_evt(input bit is_att, input int p, input bit ls);
    @(negedge clk);
    if (is_att) begin att_evt[p] = 1'b1; att_lowspd[p] = ls; end
    else det_evt[p] = 1'b1;
    @(negedge clk);
    att_evt = '0; det_evt = '0; att_lowspd = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 running", {31'd0, hc_running}, 32'd0);
    chk("R1 pulses", {29'd0, run_start, hc_rst, |bus_rst}, 32'd0);
    rd("R1 cmd", 2'd1, 5'h00, 32'h0);
    rd("R1 status", 2'd1, 5'h02, 32'h0);
    rd("R1 base", 2'd2, 5'h08, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][75]) wr(VEC[i][74:73], VEC[i][72:68], VEC[i][67:36]);
      else rd($sformatf("R%0d table[%0d]", VEC[i][3:0], i), VEC[i][74:73], VEC[i][72:68], VEC[i][35:4]);
      chk("R9 no pulse without device", {30'd0, bus_rst}, 32'd0);
    end

    // R2 start
    wr(2'd1, 5'h00, 32'h0001);
    chk("R2 run_start", {31'd0, run_start}, 32'd1);
    chk("R2 running", {31'd0, hc_running}, 32'd1);
    rd("R2 halted cleared", 2'd1, 5'h02, 32'h0);

    // R5 wrap and cause, R4 masked cause
    wr(2'd1, 5'h04, 32'h0004);
    tick(2'b01);
    rd("R5 wrap", 2'd1, 5'h06, 32'h0);
    rd("R5 usbint", 2'd1, 5'h02, 32'h1);
    chk("R4 cause0 irq", {31'd0, irq}, 32'd1);
    // R3 clear bit0 clears cause
    wr(2'd1, 5'h02, 32'h0001);
    rd("R3 status cleared", 2'd1, 5'h02, 32'h0);
    chk("R3 irq low", {31'd0, irq}, 32'd0);
    wr(2'd1, 5'h04, 32'h0008);
    tick(2'b10);
    chk("R4 cause1 irq", {31'd0, irq}, 32'd1);
    wr(2'd1, 5'h02, 32'h0002);
    chk("R3 cause kept", {31'd0, irq}, 32'd1);
    rd("R3 partial clear", 2'd1, 5'h02, 32'h1);
    wr(2'd1, 5'h02, 32'h0001);
    chk("R3 cause cleared", {31'd0, irq}, 32'd0);

    // R13 errors, R4 masking
    wr(2'd1, 5'h04, 32'h0001);
    pulse_err(3'b001);
    rd("R13 err bit", 2'd1, 5'h02, 32'h2);
    chk("R4 err enabled", {31'd0, irq}, 32'd1);
    wr(2'd1, 5'h04, 32'h0000);
    chk("R4 err masked", {31'd0, irq}, 32'd0);
    pulse_err(3'b010);
    rd("R13 sys bit", 2'd1, 5'h02, 32'hA);
    chk("R4 sys unmasked", {31'd0, irq}, 32'd1);
    pulse_err(3'b100);
    rd("R13 proc bit", 2'd1, 5'h02, 32'h1A);
    wr(2'd1, 5'h02, 32'h001A);
    chk("R3 all cleared", {31'd0, irq}, 32'd0);

    // R12 resume, R11 attach
    wr(2'd1, 5'h00, 32'h0008);
    port_evt(1'b1, 0, 1'b1);
    rd("R11 attach low", 2'd1, 5'h10, 32'h0183);
    rd("R12 force resume", 2'd1, 5'h00, 32'h0018);
    rd("R12 resume detect", 2'd1, 5'h02, 32'h0024);

    // R8 enable and W1C
    wr(2'd1, 5'h10, 32'h0004);
    rd("R8 enable", 2'd1, 5'h10, 32'h0187);
    wr(2'd1, 5'h10, 32'h0006);
    rd("R8 w1c", 2'd1, 5'h10, 32'h0185);

    // R9 reset edge
    wr(2'd1, 5'h10, 32'h0204);
    chk("R9 edge pulse", {30'd0, bus_rst}, 32'd1);
    rd("R9 port word", 2'd1, 5'h10, 32'h0385);
    wr(2'd1, 5'h10, 32'h0204);
    chk("R9 no repeat", {30'd0, bus_rst}, 32'd0);

    // R11 detach enabled port
    port_evt(1'b0, 0, 1'b0);
    rd("R11 detach", 2'd1, 5'h10, 32'h038A);

    // R7 global reset
    port_evt(1'b1, 1, 1'b0);
    wr(2'd1, 5'h00, 32'h0004);
    chk("R7 hc_rst", {31'd0, hc_rst}, 32'd1);
    chk("R7 bus reset attached only", {30'd0, bus_rst}, 32'd2);
    rd("R7 port1", 2'd1, 5'h12, 32'h0083);
    rd("R7 port0", 2'd1, 5'h10, 32'h0080);
    rd("R7 cmd", 2'd1, 5'h00, 32'h0);
    rd("R7 status", 2'd1, 5'h02, 32'h0);
    rd("R7 sof", 2'd0, 5'h0C, 32'h40);
    rd("R7 base", 2'd2, 5'h08, 32'h0);
    rd("R7 frnum kept", 2'd1, 5'h06, 32'h1);

    // R5 tick while stopped
    tick(2'b01);
    rd("R5 stopped halts", 2'd1, 5'h02, 32'h20);
    rd("R5 frnum holds", 2'd1, 5'h06, 32'h1);

    // R7 host reset: no bus reset
    wr(2'd1, 5'h00, 32'h0002);
    chk("R7 hc_rst host", {31'd0, hc_rst}, 32'd1);
    chk("R7 no bus reset", {30'd0, bus_rst}, 32'd0);
    rd("R7 status host", 2'd1, 5'h02, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule